// File: doc/BRIEF.md
# ADC Start-of-Conversion Trigger Selector

This block picks the event that starts a conversion for one sample slot of an analog-to-digital converter. A 5-bit source code chooses among a software pulse, an external start pin, two end-of-conversion pulses, four timer overflow pulses and fourteen PWM trigger pulses. The external pin is first brought into the clock domain through two flip-flops, and then watched for a rising edge, a falling edge or both, as two enables select.

Once a trigger is accepted, the block waits a programmable number of ticks before it raises a one-cycle start request. A tick comes from the ADC clock divided by 1, 2, 4 or 16. While a wait is running, further triggers are dropped and each one is reported by a one-cycle missed-trigger pulse. All configuration arrives on static ports, which are meant to change only while the block is idle.

Top module: `adc_trig_sel`

## Requirements
- R1: After reset, and until a trigger is accepted, `start_o` and `missed_o` are 0.
- R2: Source code 0 selects the software pulse `sw_trig_i`.
- R3: Source code 1 selects the external pin. The pin passes through two synchroniser flip-flops and is then edge-detected. `rise_en_i` enables 0→1 edges and `fall_en_i` enables 1→0 edges; with both set, either edge triggers, and with neither set, the pin never triggers. A pin change driven before clock edge A is taken as a trigger at edge A+2.
- R4: Codes 2 and 3 select `eoc_pulse_i[0]` and `eoc_pulse_i[1]`. Codes 4 to 7 select `tmr_ovf_i[0]` to `tmr_ovf_i[3]`.
- R5: Codes 8 to 21 (0x08 to 0x15) select `pwm_trig_i[code-8]`.
- R6: Sources that are not selected have no effect, and codes 22 to 31 never produce a trigger.
- R7: With `delay_i` = 0, an accepted trigger sampled at edge E raises `start_o` right after edge E.
- R8: With `delay_i` = N > 0 and a tick period of D cycles, `start_o` rises right after edge E + N·D.
- R9: `div_sel_i` values 0, 1, 2 and 3 give tick periods D of 1, 2, 4 and 16 ADC clock cycles.
- R10: Each accepted trigger produces exactly one `start_o` pulse, one cycle wide.
- R11: A trigger that arrives while a wait is running, including at the edge that raises `start_o` and during the cycle that `start_o` is high, is dropped. For each such trigger, `missed_o` is high for the one cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ADC clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_trig_i | input | 1 | Software trigger pulse |
| ext_pin_i | input | 1 | Asynchronous external start pin |
| eoc_pulse_i | input | 2 | End-of-conversion pulses |
| tmr_ovf_i | input | 4 | Timer overflow pulses |
| pwm_trig_i | input | 14 | PWM trigger pulses |
| src_sel_i | input | 5 | Trigger source code |
| rise_en_i | input | 1 | Accept rising edges of the pin |
| fall_en_i | input | 1 | Accept falling edges of the pin |
| div_sel_i | input | 2 | Tick divider select |
| delay_i | input | 8 | Wait length in ticks |
| start_o | output | 1 | One-cycle start-of-conversion request |
| missed_o | output | 1 | One-cycle dropped-trigger report |

## Verification
Two events can fall in the same cycle: the final tick of a running wait, which raises `start_o`, and a fresh trigger, which must be dropped and reported. The bench drives a software pulse at exactly the edge of that final tick, and again during the cycle in which `start_o` is high. It then expects `start_o` and `missed_o` to be high together, followed by `missed_o` alone. A third trigger one cycle later must be accepted and must produce its own start after the full wait.

// File: rtl/adc_trig_pkg.sv
`timescale 1ns/1ps
package adc_trig_pkg;

    localparam int PRE_W = 4;

    // fixed source code layout
    localparam int CODE_SW  = 0;
    localparam int CODE_EXT = 1;
    localparam int CODE_EOC = 2;

    typedef enum logic [1:0] {
        TICK_DIV1  = 2'd0,
        TICK_DIV2  = 2'd1,
        TICK_DIV4  = 2'd2,
        TICK_DIV16 = 2'd3
    } tick_div_e;

    // last prescaler value before a tick is issued
    function automatic logic [PRE_W-1:0] tick_last(input logic [1:0] sel);
        case (tick_div_e'(sel))
            TICK_DIV1:  tick_last = PRE_W'(0);
            TICK_DIV2:  tick_last = PRE_W'(1);
            TICK_DIV4:  tick_last = PRE_W'(3);
            default:    tick_last = PRE_W'(15);
        endcase
    endfunction

endpackage

// File: rtl/trig_pin_edge.sv
`timescale 1ns/1ps
module trig_pin_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);
    localparam int TOP = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } pin_st_t;

    pin_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[TOP-1:0], pin_i};
        st_d.prev = st_q.sync[TOP];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o =  st_q.sync[TOP] & ~st_q.prev;
    assign fall_o = ~st_q.sync[TOP] &  st_q.prev;

    // a rising edge reflects the pin level two edges earlier
    assert_rise_follows_pin_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |-> $past(pin_i, SYNC_STAGES));
    assert_fall_follows_pin_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |-> !$past(pin_i, SYNC_STAGES));

endmodule

// File: rtl/trig_src_mux.sv
`timescale 1ns/1ps
module trig_src_mux
    import adc_trig_pkg::*;
#(
    parameter int SEL_W   = 5,
    parameter int NUM_EOC = 2,
    parameter int NUM_TMR = 4,
    parameter int NUM_PWM = 14
) (
    input  logic               sw_i,
    input  logic               ext_i,
    input  logic [NUM_EOC-1:0] eoc_i,
    input  logic [NUM_TMR-1:0] tmr_i,
    input  logic [NUM_PWM-1:0] pwm_i,
    input  logic [SEL_W-1:0]   sel_i,
    output logic               trig_o
);
    localparam int TMR_BASE = CODE_EOC + NUM_EOC;
    localparam int PWM_BASE = TMR_BASE + NUM_TMR;
    localparam int END_CODE = PWM_BASE + NUM_PWM;
    localparam int VEC_W    = 1 << SEL_W;

    logic [VEC_W-1:0] src_vec;

    for (genvar i = 0; i < VEC_W; i++) begin : g_src
        if (i == CODE_SW) begin : g_sw
            assign src_vec[i] = sw_i;
        end else if (i == CODE_EXT) begin : g_ext
            assign src_vec[i] = ext_i;
        end else if (i < TMR_BASE) begin : g_eoc
            assign src_vec[i] = eoc_i[i-CODE_EOC];
        end else if (i < PWM_BASE) begin : g_tmr
            assign src_vec[i] = tmr_i[i-TMR_BASE];
        end else if (i < END_CODE) begin : g_pwm
            assign src_vec[i] = pwm_i[i-PWM_BASE];
        end else begin : g_none
            assign src_vec[i] = 1'b0;
        end
    end

    assign trig_o = src_vec[sel_i];

endmodule

// File: rtl/trig_delay.sv
`timescale 1ns/1ps
module trig_delay
    import adc_trig_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_i,
    input  logic [DLY_W-1:0] dly_i,
    input  logic [1:0]       div_sel_i,
    output logic             start_o,
    output logic             missed_o,
    output logic             busy_o
);
    typedef struct packed {
        logic             busy;
        logic             start;
        logic             missed;
        logic [PRE_W-1:0] pre;
        logic [DLY_W-1:0] cnt;
    } dly_st_t;

    dly_st_t st_d, st_q;
    logic    tick;

    assign tick = (st_q.pre == tick_last(div_sel_i));

    always_comb begin
        st_d        = st_q;
        st_d.start  = 1'b0;
        st_d.missed = 1'b0;
        if (st_q.busy) begin
            if (tick) begin
                st_d.pre = '0;
                if (st_q.cnt == DLY_W'(1)) begin
                    st_d.start = 1'b1;
                    st_d.busy  = 1'b0;
                end else begin
                    st_d.cnt = st_q.cnt - DLY_W'(1);
                end
            end else begin
                st_d.pre = st_q.pre + PRE_W'(1);
            end
        end
        if (trig_i) begin
            if (st_q.busy || st_q.start) begin
                st_d.missed = 1'b1;
            end else if (dly_i == '0) begin
                st_d.start = 1'b1;
            end else begin
                st_d.busy = 1'b1;
                st_d.cnt  = dly_i;
                st_d.pre  = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign start_o  = st_q.start;
    assign missed_o = st_q.missed;
    assign busy_o   = st_q.busy;

    assert_start_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.start |=> !st_q.start);
    assert_count_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (st_q.cnt != '0));

endmodule

// File: rtl/adc_trig_sel.sv
`timescale 1ns/1ps
module adc_trig_sel
    import adc_trig_pkg::*;
#(
    parameter int SEL_W       = 5,
    parameter int NUM_EOC     = 2,
    parameter int NUM_TMR     = 4,
    parameter int NUM_PWM     = 14,
    parameter int DLY_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sw_trig_i,
    input  logic               ext_pin_i,
    input  logic [NUM_EOC-1:0] eoc_pulse_i,
    input  logic [NUM_TMR-1:0] tmr_ovf_i,
    input  logic [NUM_PWM-1:0] pwm_trig_i,
    input  logic [SEL_W-1:0]   src_sel_i,
    input  logic               rise_en_i,
    input  logic               fall_en_i,
    input  logic [1:0]         div_sel_i,
    input  logic [DLY_W-1:0]   delay_i,
    output logic               start_o,
    output logic               missed_o
);
    localparam int LAST_CODE = CODE_EOC + NUM_EOC + NUM_TMR + NUM_PWM - 1;

    logic pin_rise, pin_fall, ext_trig, trig_w, tmr_busy;

    trig_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_pin_i),
        .rise_o (pin_rise),
        .fall_o (pin_fall)
    );

    assign ext_trig = (pin_rise & rise_en_i) | (pin_fall & fall_en_i);

    trig_src_mux #(
        .SEL_W(SEL_W), .NUM_EOC(NUM_EOC), .NUM_TMR(NUM_TMR), .NUM_PWM(NUM_PWM)
    ) u_mux (
        .sw_i   (sw_trig_i),
        .ext_i  (ext_trig),
        .eoc_i  (eoc_pulse_i),
        .tmr_i  (tmr_ovf_i),
        .pwm_i  (pwm_trig_i),
        .sel_i  (src_sel_i),
        .trig_o (trig_w)
    );

    trig_delay #(.DLY_W(DLY_W)) u_dly (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_i    (trig_w),
        .dly_i     (delay_i),
        .div_sel_i (div_sel_i),
        .start_o   (start_o),
        .missed_o  (missed_o),
        .busy_o    (tmr_busy)
    );

    assert_unused_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel_i > SEL_W'(LAST_CODE)) |-> !trig_w);
    assert_zero_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_w && delay_i == '0 && !tmr_busy && !start_o) |=> start_o);
    assert_missed_has_trig_R11: assert property (@(posedge clk) disable iff (!rst_n)
        missed_o |-> $past(trig_w));

endmodule

// File: tb/tb_adc_trig_sel.sv
`timescale 1ns/1ps
module tb_adc_trig_sel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_trig_i = 1'b0;
    logic        ext_pin_i = 1'b0;
    logic [1:0]  eoc_pulse_i = '0;
    logic [3:0]  tmr_ovf_i = '0;
    logic [13:0] pwm_trig_i = '0;
    logic [4:0]  src_sel_i = '0;
    logic        rise_en_i = 1'b0;
    logic        fall_en_i = 1'b0;
    logic [1:0]  div_sel_i = '0;
    logic [7:0]  delay_i = '0;
    logic        start_o, missed_o;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    adc_trig_sel dut (
        .clk(clk), .rst_n(rst_n), .sw_trig_i(sw_trig_i), .ext_pin_i(ext_pin_i),
        .eoc_pulse_i(eoc_pulse_i), .tmr_ovf_i(tmr_ovf_i), .pwm_trig_i(pwm_trig_i),
        .src_sel_i(src_sel_i), .rise_en_i(rise_en_i), .fall_en_i(fall_en_i),
        .div_sel_i(div_sel_i), .delay_i(delay_i), .start_o(start_o), .missed_o(missed_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive_code(input int code, input logic v);
        if (code == 0)       sw_trig_i = v;
        else if (code < 4)   eoc_pulse_i[code-2] = v;
        else if (code < 8)   tmr_ovf_i[code-4] = v;
        else if (code < 22)  pwm_trig_i[code-8] = v;
    endtask

    // one-cycle pulse; returns at the first negedge after the sampling edge
    task automatic pulse_code(input int code);
        @(negedge clk);
        drive_code(code, 1'b1);
        @(negedge clk);
        drive_code(code, 1'b0);
    endtask

    // lat: negedges after the trigger edge at which start must appear (1 = next)
    task automatic measure(input int lat, input string req);
        int first = 0;
        int highs = 0;
        for (int k = 1; k <= lat + 2; k++) begin
            if (k > 1) @(negedge clk);
            if (start_o) begin
                highs++;
                if (first == 0) first = k;
            end
        end
        chk(first == lat && highs == 1, req, first, lat);
    endtask

    task automatic expect_none(input int n, input string req);
        int highs = 0;
        for (int k = 1; k <= n; k++) begin
            if (k > 1) @(negedge clk);
            if (start_o) highs++;
        end
        chk(highs == 0, req, highs, 0);
    endtask

    task automatic ext_drive(input logic v);
        @(negedge clk);
        ext_pin_i = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk(start_o == 1'b0, "R1 start after reset", int'(start_o), 0);
        chk(missed_o == 1'b0, "R1 missed after reset", int'(missed_o), 0);
        repeat (4) @(negedge clk);
        chk(start_o == 1'b0 && missed_o == 1'b0, "R1 idle", int'(start_o), 0);
    endtask

    task automatic test_sw();
        src_sel_i = 5'd0; delay_i = 8'd0; div_sel_i = 2'd0;
        pulse_code(0);
        measure(1, "R2 software trigger");
    endtask

    task automatic test_sources();
        delay_i = 8'd0;
        for (int c = 2; c < 22; c++) begin
            src_sel_i = 5'(c);
            pulse_code(c);
            measure(1, (c < 8) ? "R4 eoc/timer source" : "R5 pwm source");
        end
    endtask

    task automatic test_unselected();
        delay_i = 8'd0;
        rise_en_i = 1'b1; fall_en_i = 1'b1;
        src_sel_i = 5'd4;
        @(negedge clk);
        sw_trig_i = 1'b1; tmr_ovf_i = 4'b1110; pwm_trig_i = '1; eoc_pulse_i = '1;
        @(negedge clk);
        sw_trig_i = 1'b0; tmr_ovf_i = '0; pwm_trig_i = '0; eoc_pulse_i = '0;
        expect_none(8, "R6 unselected sources");
        for (int s = 22; s < 32; s += 9) begin
            src_sel_i = 5'(s);
            @(negedge clk);
            sw_trig_i = 1'b1; tmr_ovf_i = '1; pwm_trig_i = '1; eoc_pulse_i = '1;
            ext_pin_i = ~ext_pin_i;
            @(negedge clk);
            sw_trig_i = 1'b0; tmr_ovf_i = '0; pwm_trig_i = '0; eoc_pulse_i = '0;
            expect_none(8, "R6 unused code");
        end
        rise_en_i = 1'b0; fall_en_i = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic test_ext();
        src_sel_i = 5'd1; delay_i = 8'd0; div_sel_i = 2'd0;
        rise_en_i = 1'b1; fall_en_i = 1'b0;
        ext_drive(1'b1); measure(1, "R3 rise-only rising");
        ext_drive(1'b0); expect_none(6, "R3 rise-only falling");
        rise_en_i = 1'b0; fall_en_i = 1'b1;
        ext_drive(1'b1); expect_none(6, "R3 fall-only rising");
        ext_drive(1'b0); measure(1, "R3 fall-only falling");
        rise_en_i = 1'b1; fall_en_i = 1'b1;
        ext_drive(1'b1); measure(1, "R3 both rising");
        ext_drive(1'b0); measure(1, "R3 both falling");
        rise_en_i = 1'b0; fall_en_i = 1'b0;
        ext_drive(1'b1); expect_none(6, "R3 neither rising");
        ext_drive(1'b0); expect_none(6, "R3 neither falling");
        rise_en_i = 1'b1; delay_i = 8'd2; div_sel_i = 2'd2;
        ext_drive(1'b1); measure(9, "R3 R8 pin with delay");
        rise_en_i = 1'b0;
        ext_drive(1'b0);
        repeat (4) @(negedge clk);
    endtask

    task automatic run_delay(input int d, input int dv, input int per, input string req);
        src_sel_i = 5'd0; delay_i = 8'(d); div_sel_i = 2'(dv);
        pulse_code(0);
        measure(d * per + 1, req);
    endtask

    task automatic test_delay();
        run_delay(0, 3, 16, "R7 zero delay ignores divider");
        run_delay(5, 0, 1, "R8 delay 5 div1");
        run_delay(3, 1, 2, "R9 div2");
        run_delay(2, 2, 4, "R9 div4");
        run_delay(2, 3, 16, "R9 div16");
        run_delay(1, 3, 16, "R8 delay 1 div16");
        run_delay(255, 0, 1, "R8 max delay");
    endtask

    // triggers at cycles 0,2,6,7,8 with wait of 3 ticks x 2 cycles
    task automatic test_overlap();
        src_sel_i = 5'd0; delay_i = 8'd3; div_sel_i = 2'd1;
        for (int c = 0; c < 20; c++) begin
            bit es, em;
            @(negedge clk);
            sw_trig_i = (c == 0 || c == 2 || c == 6 || c == 7 || c == 8);
            @(posedge clk);
            #1;
            sw_trig_i = 1'b0;
            es = (c == 6 || c == 14);
            em = (c == 2 || c == 6 || c == 7);
            chk(start_o == es, "R11 R10 start during overlap", int'(start_o), int'(es));
            chk(missed_o == em, "R11 missed report", int'(missed_o), int'(em));
        end
        // zero delay: trigger in the start cycle is dropped
        delay_i = 8'd0;
        for (int c = 0; c < 4; c++) begin
            bit es, em;
            @(negedge clk);
            sw_trig_i = (c < 2);
            @(posedge clk);
            #1;
            sw_trig_i = 1'b0;
            es = (c == 0);
            em = (c == 1);
            chk(start_o == es, "R11 zero-delay start", int'(start_o), int'(es));
            chk(missed_o == em, "R11 zero-delay missed", int'(missed_o), int'(em));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_sw();
        test_sources();
        test_unselected();
        test_ext();
        test_delay();
        test_overlap();
        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule